// File: doc/BRIEF.md
# Pending-and-Mask Interrupt Controller

This block gathers up to sixteen peripheral interrupt sources into one interrupt request line for the processor. Each source raises a one-cycle request pulse. The pulse sets a sticky bit in a pending register, and the bit stays set until software acknowledges it. A second register holds one enable bit per source. The processor line is raised whenever a pending bit is also enabled.

Software reaches both registers over a simple register bus with an address, a write strobe, 32-bit write data and combinational 32-bit read data. The pending register sits at offset 0x070 and the enable register at offset 0x074. A write to the pending register is an acknowledge: the written word is ANDed into the register. A zero clears its bit, and a one leaves its bit as it was. Source bit 3 is the one driven by the DMA engine's interrupt logic. It is latched and acknowledged the same way as every other bit.

Top module: `intc_pend_mask`

## Requirements
- R1: After reset both registers read as zero and `cpu_irq` is low.
- R2: A high `src_req[i]` on a clock edge sets pending bit i. The bit stays set after the pulse ends, until software acknowledges it.
- R3: A write to offset 0x070 replaces the pending register with (old pending AND write data[15:0]). A written 0 clears its bit, and a written 1 never sets a bit that was clear.
- R4: If a source pulse and an acknowledge that clears the same bit fall on the same edge, the bit ends up set.
- R5: A write to offset 0x074 replaces all 16 enable bits with write data[15:0]. Without such a write the enable register holds its value.
- R6: `cpu_irq` is registered. One cycle after any edge, it equals the OR over all bits of (pending AND enable) as they stood after that edge.
- R7: A read at 0x070 returns the pending register, and a read at 0x074 returns the enable register, each in bits 15:0 with bits 31:16 zero. Any other offset reads as zero.
- R8: Bits 31:16 of write data have no effect. A write to any offset other than 0x070 or 0x074 changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 12 | Register offset |
| bus_wr | input | 1 | Write strobe, one write per cycle while high |
| bus_wdata | input | 32 | Write data; only bits 15:0 are used |
| bus_rdata | output | 32 | Read data for `bus_addr`, zero-extended |
| src_req | input | 16 | Per-source request pulses; bit 3 is the DMA source |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach from the ports is a source pulse landing on the same edge as an acknowledge that clears that same bit. Only that collision shows whether set beats clear. The stimulus forces it on purpose: it writes zeros to the pending register while pulsing bit 3, then repeats the collision on other bits. A long random phase mixes sparse pulses with acknowledges, enable writes and writes to an unmapped offset, so collisions and enable changes also land next to each other. A behavioural model in the bench tracks both registers and the delayed line, and the outputs are compared against it every cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned PEND_OFS = 'h070;
  localparam int unsigned ENAB_OFS = 'h074;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PEND = 2'd1,
    SEL_ENAB = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_SRC  = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [N_SRC-1:0]  pend_i,
  input  logic [N_SRC-1:0]  enab_i,
  output logic              wr_pend_o,
  output logic              wr_enab_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - N_SRC;

  reg_sel_e sel;

  always_comb begin
    if (addr_i == ADDR_W'(PEND_OFS))      sel = SEL_PEND;
    else if (addr_i == ADDR_W'(ENAB_OFS)) sel = SEL_ENAB;
    else                                  sel = SEL_NONE;
  end

  always_comb begin
    wr_pend_o = wr_i && (sel == SEL_PEND);
    wr_enab_o = wr_i && (sel == SEL_ENAB);
  end

  always_comb begin
    unique case (sel)
      SEL_PEND: rdata_o = {{PAD_W{1'b0}}, pend_i};
      SEL_ENAB: rdata_o = {{PAD_W{1'b0}}, enab_i};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/intc_pend_bank.sv
module intc_pend_bank #(
  parameter int unsigned N_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_wr_i,
  input  logic [N_SRC-1:0] ack_data_i,
  input  logic [N_SRC-1:0] src_i,
  output logic [N_SRC-1:0] pend_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    logic bit_q;
    logic bit_d;
    logic bit_en;

    always_comb begin
      bit_en = ack_wr_i | src_i[i];
      bit_d  = (ack_wr_i ? (bit_q & ack_data_i[i]) : bit_q) | src_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (bit_en) bit_q <= bit_d;
    end

    assign pend_o[i] = bit_q;

    // R2: a request pulse leaves its bit set
    a_r2_src_sets: assert property (@(posedge clk) disable iff (!rst_n)
      src_i[i] |=> bit_q);
    // R3: a clear bit never sets itself without a request
    a_r3_no_self_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_q && !src_i[i]) |=> !bit_q);
    // R3: a written zero acknowledges the bit
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr_i && !ack_data_i[i] && !src_i[i]) |=> !bit_q);
    // R4: set beats clear on a collision
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr_i && !ack_data_i[i] && src_i[i]) |=> bit_q);
  end
endmodule

// File: rtl/intc_enab_reg.sv
module intc_enab_reg #(
  parameter int unsigned N_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] enab_o
);
  logic [N_SRC-1:0] enab_q;
  logic [N_SRC-1:0] enab_d;

  always_comb begin
    enab_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    enab_q <= '0;
    else if (wr_i) enab_q <= enab_d;
  end

  assign enab_o = enab_q;

  a_r5_enab_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (enab_o == $past(wdata_i)));
  a_r5_enab_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(enab_o));
endmodule

// File: rtl/intc_irq_gen.sv
module intc_irq_gen #(
  parameter int unsigned N_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] enab_i,
  output logic             irq_o
);
  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = |(pend_i & enab_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  a_r6_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(pend_i & enab_i))));
  a_r6_no_irq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (enab_i == '0) |=> !irq_o);
endmodule

// File: rtl/intc_pend_mask.sv
module intc_pend_mask #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_SRC  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_SRC-1:0]  src_req,
  output logic              cpu_irq
);
  logic             rst_sync_n;
  logic             wr_pend;
  logic             wr_enab;
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] enab;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:N_SRC];

  intc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  intc_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SRC(N_SRC)) u_dec (
    .addr_i    (bus_addr),
    .wr_i      (bus_wr),
    .pend_i    (pend),
    .enab_i    (enab),
    .wr_pend_o (wr_pend),
    .wr_enab_o (wr_enab),
    .rdata_o   (bus_rdata)
  );

  intc_pend_bank #(.N_SRC(N_SRC)) u_pend (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ack_wr_i   (wr_pend),
    .ack_data_i (bus_wdata[N_SRC-1:0]),
    .src_i      (src_req),
    .pend_o     (pend)
  );

  intc_enab_reg #(.N_SRC(N_SRC)) u_enab (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_i    (wr_enab),
    .wdata_i (bus_wdata[N_SRC-1:0]),
    .enab_o  (enab)
  );

  intc_irq_gen #(.N_SRC(N_SRC)) u_irq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pend_i (pend),
    .enab_i (enab),
    .irq_o  (cpu_irq)
  );

  // R8: a write elsewhere touches neither register
  a_r8_stray_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_pend && !wr_enab && src_req == '0) |=> ($stable(pend) && $stable(enab)));
endmodule

// File: tb/tb_intc_pend_mask.sv
`timescale 1ns/1ps
module tb_intc_pend_mask;
  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] src_req;
  logic        cpu_irq;

  int checks;
  int fails;
  logic [15:0] m_pend;
  logic [15:0] m_enab;
  logic        m_irq;

  intc_pend_mask dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_req   (src_req),
    .cpu_irq   (cpu_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One bus cycle: drive, let the edge pass, update the model, compare.
  task automatic step(input logic [11:0] a, input logic w, input logic [31:0] d,
                      input logic [15:0] s, input string tag);
    logic [15:0] old_p;
    logic [15:0] old_e;
    logic [31:0] exp_rd;
    bus_addr = a; bus_wr = w; bus_wdata = d; src_req = s;
    @(posedge clk);
    old_p = m_pend; old_e = m_enab;
    if (w && a == 12'h070) m_pend = m_pend & d[15:0];
    m_pend = m_pend | s;
    if (w && a == 12'h074) m_enab = d[15:0];
    m_irq = (old_p & old_e) != 16'h0;
    @(negedge clk);
    if (a == 12'h070)      exp_rd = {16'h0, m_pend};
    else if (a == 12'h074) exp_rd = {16'h0, m_enab};
    else                   exp_rd = 32'h0;
    check(tag, "rdata", bus_rdata, exp_rd);
    check(tag, "cpu_irq", {31'h0, cpu_irq}, {31'h0, m_irq});
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    step(a, 1'b0, 32'h0, 16'h0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    m_pend = '0; m_enab = '0; m_irq = 1'b0;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; src_req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(12'h070, "R1");
    rd(12'h074, "R1");

    // R2 sticky set, enable still zero so no irq
    step(12'h070, 1'b0, 32'h0, 16'h0020, "R2");
    rd(12'h070, "R2");
    rd(12'h070, "R2");

    // R5 and R8: upper bits dropped, mask replaced; R6 irq one cycle later
    step(12'h074, 1'b1, 32'hDEAD_0020, 16'h0, "R5");
    rd(12'h074, "R6");
    rd(12'h074, "R6");
    step(12'h074, 1'b1, 32'hFFFF_0001, 16'h0, "R5");
    rd(12'h070, "R6");
    rd(12'h070, "R6");

    // R3: ones keep, zero clears
    step(12'h070, 1'b1, 32'h0000_FFFF, 16'h0, "R3");
    rd(12'h070, "R3");
    step(12'h070, 1'b1, 32'hFFFF_FFDF, 16'h0, "R3");
    rd(12'h070, "R3");

    // R4: collision on the DMA bit and on bit 15
    step(12'h074, 1'b1, 32'h0000_8008, 16'h0, "R5");
    step(12'h070, 1'b1, 32'h0000_0000, 16'h0008, "R4");
    rd(12'h070, "R4");
    rd(12'h070, "R6");
    step(12'h070, 1'b1, 32'h0000_0008, 16'h8000, "R4");
    rd(12'h070, "R4");

    // R7 and R8: unmapped read and write
    rd(12'h078, "R7");
    step(12'h078, 1'b1, 32'h0000_0000, 16'h0, "R8");
    rd(12'h070, "R8");
    rd(12'h074, "R8");
    step(12'h070, 1'b1, 32'h0000_0000, 16'h0, "R3");
    rd(12'h070, "R6");

    // Mixed random traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      logic [15:0] s;
      logic w;
      case ($urandom % 3)
        0: a = 12'h070;
        1: a = 12'h074;
        default: a = 12'h078;
      endcase
      s = (($urandom % 3) == 0) ? 16'(1 << ($urandom % 16)) : 16'h0;
      w = (($urandom % 3) == 0);
      step(a, w, $urandom, s, "R6");
    end

    summary();
    $finish;
  end
endmodule